// File: doc/BRIEF.md
# Shared SRAM Switch with Hardware Mutexes

This block shares one external asynchronous-read SRAM port among three kinds of client. A clearing sequencer runs once after reset and zeroes every word. A video scanout reader fetches one word per cycle whenever it asks. A set of CPUs each run a request/acknowledge handshake. While a video read is pending the video reader owns the port. A CPU can be granted only while the active-low blanking input is low.

Each CPU places an operation code, a byte address and write data on its lanes, raises its request and waits for its acknowledge. It then takes its read result and drops the request. Operations are word read, single-byte write, 16-bit word write, and three operations on a bank of eight mutex bits: test-and-set, clear and read. A mutex operation is decided at the single grant point, so two CPUs racing on one mutex always see exactly one winner.

The switch is a three-state machine. **ST_WIPE** drives the clearing writes and leaves on the *sweep-done* transition when the last address is written. **ST_SERVE** serves video and looks for a CPU to grant; the *grant* transition performs the operation and moves to **ST_HOLD**. **ST_HOLD** keeps the acknowledge raised and returns to ST_SERVE on the *release* transition, when the owner's request falls.

Top module: `shared_sram_switch`

## Requirements
- R1: After reset the switch writes zero to every word from address 0 upward, one word per cycle. No CPU is acknowledged and no video data is marked valid until the sweep ends.
- R2: While `vid_req` is high in ST_SERVE, the SRAM address is `vid_addr`. The word appears on `vid_rdata` with `vid_rvalid` high one cycle later, and no CPU is granted in that cycle.
- R3: A CPU is granted only in a cycle where `blank_n` is low.
- R4: Among pending CPUs, those requesting memory operations (codes 0, 1, 2, 6, 7) beat those requesting mutex operations (codes 3, 4, 5). Within each class the lowest CPU index wins.
- R5: An acknowledge rises one clock after its grant and stays high while the request stays high. It falls one clock after the request falls, and at most one acknowledge is high at any time.
- R6: A read (code 0, also 6 and 7) returns the 16-bit word at address bits [AW:1]. The value on the CPU's read lane stays stable while its acknowledge is high.
- R7: A byte write (code 1) stores wdata[7:0] into the low byte when address bit 0 is 0, and into the high byte when it is 1. The other byte is unchanged.
- R8: A word write (code 2) stores all 16 bits of wdata at address bits [AW:1]; address bit 0 is ignored.
- R9: Test-and-set (code 3) on mutex address[2:0] returns the prior state in bit 0 (other bits 0) and leaves the mutex set.
- R10: Clear (code 4) forces the mutex to 0 and returns 0. Mutex read (code 5) returns its state in bit 0 and changes no mutex.
- R11: When two CPUs request test-and-set on the same free mutex together, the lower-index CPU gets 0. The other is served afterwards and gets 1.
- R12: With several CPUs pending on memory operations, they are served in index order. A lower-priority CPU is served once the higher ones drop their requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; starts the clearing sweep |
| blank_n | input | 1 | Active-low blanking; CPUs may be granted only while low |
| vid_req | input | 1 | Video reader wants the port this cycle |
| vid_addr | input | AW | Video word address |
| vid_rdata | output | DW | Word fetched for the video reader |
| vid_rvalid | output | 1 | vid_rdata holds the word requested in the previous cycle |
| cpu_req | input | NCPU | Per-CPU request |
| cpu_op | input | 3*NCPU | Per-CPU operation code |
| cpu_addr | input | (AW+1)*NCPU | Per-CPU byte address; bits [2:0] select a mutex |
| cpu_wdata | input | DW*NCPU | Per-CPU write data |
| cpu_ack | output | NCPU | Per-CPU acknowledge |
| cpu_rdata | output | DW*NCPU | Per-CPU read result, held while acknowledged |
| sram_addr | output | AW | SRAM word address |
| sram_wdata | output | DW | SRAM write data |
| sram_be | output | 2 | SRAM byte-lane enables (bit 0 low byte) |
| sram_we | output | 1 | SRAM write strobe, taken at the clock edge |
| sram_rdata | input | DW | SRAM read data, valid in the same cycle as the address |

## Verification
The bench builds the switch with AW=6, so the 64-cycle clearing sweep finishes quickly and every address of it can be compared in order. The bench also confirms that all 64 words of its model memory end at zero. NCPU=3 and NMUTEX=8 are kept, which covers a three-way ordering, a memory-versus-mutex contest between the lowest and highest CPU, and a same-cycle test-and-set race.

// File: rtl/ssw_pkg.sv
package ssw_pkg;

    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WBYTE = 3'd1,
        OP_WWORD = 3'd2,
        OP_TAS   = 3'd3,
        OP_MCLR  = 3'd4,
        OP_MREAD = 3'd5
    } ssw_op_e;

    typedef enum logic [1:0] {
        ST_WIPE,
        ST_SERVE,
        ST_HOLD
    } ssw_state_e;

    function automatic logic op_is_mutex(input logic [2:0] op);
        return (op == OP_TAS) || (op == OP_MCLR) || (op == OP_MREAD);
    endfunction

endpackage

// File: rtl/ssw_wiper.sv
module ssw_wiper #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] addr,
    output logic          last
);
    localparam logic [AW-1:0] LAST_ADDR = {AW{1'b1}};

    logic [AW-1:0] cnt_q;
    logic          run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b1;
        end else if (run_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST_ADDR) run_q <= 1'b0;
        end
    end

    assign addr = cnt_q;
    assign last = run_q && (cnt_q == LAST_ADDR);

    // R1: addresses advance by one per cycle during the sweep
    assert_sweep_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !last) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/ssw_picker.sv
module ssw_picker #(
    parameter int N  = 3,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  is_mut,
    output logic          vld,
    output logic [IW-1:0] idx
);
    logic [N-1:0] mem_req;
    logic [N-1:0] pool;

    for (genvar g = 0; g < N; g++) begin : g_class
        assign mem_req[g] = req[g] & ~is_mut[g];
    end

    assign pool = (|mem_req) ? mem_req : req;

    always_comb begin
        vld = |pool;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pool[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/ssw_locks.sv
module ssw_locks
    import ssw_pkg::*;
#(
    parameter int NM = 8,
    parameter int MW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [2:0]    op,
    input  logic [MW-1:0] sel,
    output logic          cur
);
    logic [NM-1:0] lk_q;

    assign cur = lk_q[sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_q <= '0;
        end else if (en) begin
            if (op == OP_TAS)       lk_q[sel] <= 1'b1;
            else if (op == OP_MCLR) lk_q[sel] <= 1'b0;
        end
    end

    assert_tas_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OP_TAS) |=> lk_q[$past(sel)]);

    assert_clear_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OP_MCLR) |=> !lk_q[$past(sel)]);

    assert_read_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OP_MREAD) |=> (lk_q == $past(lk_q)));

endmodule

// File: rtl/shared_sram_switch.sv
module shared_sram_switch
    import ssw_pkg::*;
#(
    parameter int AW     = 8,
    parameter int DW     = 16,
    parameter int NCPU   = 3,
    parameter int NMUTEX = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    blank_n,
    input  logic                    vid_req,
    input  logic [AW-1:0]           vid_addr,
    output logic [DW-1:0]           vid_rdata,
    output logic                    vid_rvalid,
    input  logic [NCPU-1:0]         cpu_req,
    input  logic [3*NCPU-1:0]       cpu_op,
    input  logic [(AW+1)*NCPU-1:0]  cpu_addr,
    input  logic [DW*NCPU-1:0]      cpu_wdata,
    output logic [NCPU-1:0]         cpu_ack,
    output logic [DW*NCPU-1:0]      cpu_rdata,
    output logic [AW-1:0]           sram_addr,
    output logic [DW-1:0]           sram_wdata,
    output logic [1:0]              sram_be,
    output logic                    sram_we,
    input  logic [DW-1:0]           sram_rdata
);
    localparam int IW  = (NCPU > 1) ? $clog2(NCPU) : 1;
    localparam int MW  = (NMUTEX > 1) ? $clog2(NMUTEX) : 1;
    localparam int BW  = DW / 2;
    localparam int CAW = AW + 1;
    localparam int OPW = 3;

    // per-CPU lanes
    logic [OPW-1:0] op_a   [NCPU];
    logic [CAW-1:0] addr_a [NCPU];
    logic [DW-1:0]  wd_a   [NCPU];
    logic [DW-1:0]  rdata_q[NCPU];
    logic [NCPU-1:0] mut_v;
    logic [NCPU-1:0] ack_q;

    for (genvar g = 0; g < NCPU; g++) begin : g_lane
        assign op_a[g]   = cpu_op[g*OPW +: OPW];
        assign addr_a[g] = cpu_addr[g*CAW +: CAW];
        assign wd_a[g]   = cpu_wdata[g*DW +: DW];
        assign mut_v[g]  = op_is_mutex(op_a[g]);
        assign cpu_rdata[g*DW +: DW] = rdata_q[g];
    end

    ssw_state_e     state_q, state_d;
    logic [IW-1:0]  owner_q;
    logic           pick_vld;
    logic [IW-1:0]  pick_idx;
    logic [AW-1:0]  wipe_addr;
    logic           wipe_last;
    logic           grant;
    logic           lock_en;
    logic           lock_bit;
    logic           lock_res;
    logic [OPW-1:0] sel_op;
    logic [CAW-1:0] sel_addr;
    logic [DW-1:0]  sel_wd;
    logic           sel_mut;
    logic [DW-1:0]  vid_rdata_q;
    logic           vid_rvalid_q;

    ssw_wiper #(.AW(AW)) u_wipe (
        .clk  (clk),
        .rst_n(rst_n),
        .addr (wipe_addr),
        .last (wipe_last)
    );

    ssw_picker #(.N(NCPU), .IW(IW)) u_pick (
        .req   (cpu_req),
        .is_mut(mut_v),
        .vld   (pick_vld),
        .idx   (pick_idx)
    );

    assign sel_op   = op_a[pick_idx];
    assign sel_addr = addr_a[pick_idx];
    assign sel_wd   = wd_a[pick_idx];
    assign sel_mut  = mut_v[pick_idx];

    assign grant   = (state_q == ST_SERVE) && !vid_req && !blank_n && pick_vld;
    assign lock_en = grant && sel_mut;

    ssw_locks #(.NM(NMUTEX), .MW(MW)) u_locks (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (lock_en),
        .op   (sel_op),
        .sel  (sel_addr[MW-1:0]),
        .cur  (lock_bit)
    );

    assign lock_res = (sel_op == OP_MCLR) ? 1'b0 : lock_bit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WIPE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WIPE:  if (wipe_last)        state_d = ST_SERVE;
            ST_SERVE: if (grant)            state_d = ST_HOLD;
            ST_HOLD:  if (!cpu_req[owner_q]) state_d = ST_SERVE;
            default:                        state_d = ST_WIPE;
        endcase
    end

    // SRAM port outputs
    always_comb begin
        sram_addr  = vid_addr;
        sram_wdata = '0;
        sram_be    = 2'b11;
        sram_we    = 1'b0;
        unique case (state_q)
            ST_WIPE: begin
                sram_addr = wipe_addr;
                sram_we   = 1'b1;
            end
            ST_SERVE: begin
                if (grant && !sel_mut) begin
                    sram_addr = sel_addr[CAW-1:1];
                    if (sel_op == OP_WBYTE) begin
                        sram_we    = 1'b1;
                        sram_be    = sel_addr[0] ? 2'b10 : 2'b01;
                        sram_wdata = {2{sel_wd[BW-1:0]}};
                    end else if (sel_op == OP_WWORD) begin
                        sram_we    = 1'b1;
                        sram_wdata = sel_wd;
                    end
                end
            end
            ST_HOLD: begin
                sram_addr = vid_addr;
            end
            default: begin
                sram_addr = vid_addr;
            end
        endcase
    end

    // handshake and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q        <= '0;
            owner_q      <= '0;
            vid_rvalid_q <= 1'b0;
            vid_rdata_q  <= '0;
            for (int i = 0; i < NCPU; i++) rdata_q[i] <= '0;
        end else begin
            vid_rvalid_q <= (state_q == ST_SERVE) && vid_req;
            if ((state_q == ST_SERVE) && vid_req) vid_rdata_q <= sram_rdata;
            if (grant) begin
                ack_q[pick_idx]   <= 1'b1;
                owner_q           <= pick_idx;
                rdata_q[pick_idx] <= sel_mut ? {{(DW-1){1'b0}}, lock_res} : sram_rdata;
            end
            if ((state_q == ST_HOLD) && !cpu_req[owner_q]) ack_q[owner_q] <= 1'b0;
        end
    end

    assign cpu_ack    = ack_q;
    assign vid_rdata  = vid_rdata_q;
    assign vid_rvalid = vid_rvalid_q;

    // checks on the handshake and arbitration
    assert_single_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cpu_ack));

    assert_wipe_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WIPE) |-> (cpu_ack == '0 && !vid_rvalid));

    for (genvar g = 0; g < NCPU; g++) begin : g_chk
        assert_blank_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(cpu_ack[g]) |-> !$past(blank_n));

        assert_video_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(cpu_ack[g]) |-> !$past(vid_req));

        assert_hold_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_ack[g] && cpu_req[g]) |=> cpu_ack[g]);

        assert_rdata_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_ack[g] && $past(cpu_ack[g])) |-> $stable(cpu_rdata[g*DW +: DW]));

        assert_mem_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(cpu_ack[g]) && $past(mut_v[g])) |-> !$past(|(cpu_req & ~mut_v)));
    end

endmodule

// File: tb/shared_sram_switch_bench.sv
module shared_sram_switch_bench;
    localparam int AW = 6, DW = 16, NCPU = 3, NMUTEX = 8, CAW = AW + 1;
    localparam logic [2:0] C_RD = 3'd0, C_WB = 3'd1, C_WW = 3'd2,
                           C_TAS = 3'd3, C_CLR = 3'd4, C_MRD = 3'd5;

    logic clk, rst_n, blank_n, vid_req, vid_rvalid, sram_we;
    logic [AW-1:0] vid_addr, sram_addr;
    logic [DW-1:0] vid_rdata, sram_wdata, sram_rdata;
    logic [NCPU-1:0] cpu_req, cpu_ack;
    logic [3*NCPU-1:0] cpu_op;
    logic [CAW*NCPU-1:0] cpu_addr;
    logic [DW*NCPU-1:0] cpu_wdata, cpu_rdata;
    logic [1:0] sram_be;

    int checks = 0, errors = 0;
    bit done = 0, multi = 0;

    shared_sram_switch #(.AW(AW), .DW(DW), .NCPU(NCPU), .NMUTEX(NMUTEX)) u_shared_sram_switch (
        .clk(clk), .rst_n(rst_n), .blank_n(blank_n),
        .vid_req(vid_req), .vid_addr(vid_addr), .vid_rdata(vid_rdata), .vid_rvalid(vid_rvalid),
        .cpu_req(cpu_req), .cpu_op(cpu_op), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_be(sram_be),
        .sram_we(sram_we), .sram_rdata(sram_rdata)
    );

    initial clk = 0;
    always #5 clk = ~clk;

    // behavioural SRAM: asynchronous read, write at the clock edge
    logic [DW-1:0] mem [64];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= 16'hA5A5 ^ 16'(i);
        end else if (sram_we) begin
            if (sram_be[0]) mem[sram_addr][7:0]  <= sram_wdata[7:0];
            if (sram_be[1]) mem[sram_addr][15:8] <= sram_wdata[15:8];
        end
    end
    assign sram_rdata = mem[sram_addr];

    always @(negedge clk) if (rst_n && $countones(cpu_ack) > 1) multi = 1;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic drive(input int i, input logic [2:0] op, input logic [CAW-1:0] a, input logic [DW-1:0] d);
        cpu_op[i*3 +: 3]       = op;
        cpu_addr[i*CAW +: CAW] = a;
        cpu_wdata[i*DW +: DW]  = d;
        cpu_req[i]             = 1'b1;
    endtask

    function automatic logic [DW-1:0] rd_of(input int i);
        return cpu_rdata[i*DW +: DW];
    endfunction

    task automatic wait_ack(input int i, input int maxc, output bit got);
        got = 0;
        for (int n = 0; n < maxc && !got; n++) begin
            @(negedge clk);
            if (cpu_ack[i]) got = 1;
        end
    endtask

    task automatic txn(input int i, input logic [2:0] op, input logic [CAW-1:0] a,
                       input logic [DW-1:0] d, input string rq, output logic [DW-1:0] rd);
        bit got;
        logic [DW-1:0] first;
        @(negedge clk);
        drive(i, op, a, d);
        wait_ack(i, 8, got);
        chk(got, {rq, " ack"}, 32'(got), 1);
        first = rd_of(i);
        @(negedge clk);
        chk(cpu_ack[i] && rd_of(i) == first, "R5 R6 hold", 32'(rd_of(i)), 32'(first));
        cpu_req[i] = 1'b0;
        @(negedge clk);
        chk(!cpu_ack[i], "R5 ack fall", 32'(cpu_ack[i]), 0);
        rd = first;
    endtask

    task automatic t_wipe;
        int bad = 0, nz = 0;
        bit got;
        drive(0, C_RD, CAW'(10), '0);
        repeat (3) @(negedge clk);
        rst_n = 1;
        for (int k = 0; k < 64; k++) begin
            #1;
            if (!(sram_we && sram_addr == AW'(k) && !cpu_ack[0] && !vid_rvalid)) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R1 sweep order", bad, 0);
        wait_ack(0, 3, got);
        chk(got, "R1 served after sweep", 32'(got), 1);
        chk(rd_of(0) == 0, "R1 word cleared", 32'(rd_of(0)), 0);
        cpu_req[0] = 0;
        @(negedge clk);
        for (int i = 0; i < 64; i++) if (mem[i] != 0) nz++;
        chk(nz == 0, "R1 all words zero", nz, 0);
    endtask

    task automatic t_rw;
        logic [DW-1:0] rd;
        txn(1, C_WW, CAW'(7), 16'h1234, "R8 wr", rd);
        txn(1, C_RD, CAW'(6), '0, "R8 rd", rd);
        chk(rd == 16'h1234, "R8 word write", 32'(rd), 32'h1234);
        txn(1, C_WB, CAW'(7), 16'h77AB, "R7 wr hi", rd);
        txn(1, C_RD, CAW'(6), '0, "R7 rd", rd);
        chk(rd == 16'hAB34, "R7 high byte", 32'(rd), 32'hAB34);
        txn(1, C_WB, CAW'(6), 16'h00CD, "R7 wr lo", rd);
        txn(1, C_RD, CAW'(7), '0, "R6 rd", rd);
        chk(rd == 16'hABCD, "R7 low byte R6 read", 32'(rd), 32'hABCD);
    endtask

    task automatic t_video;
        logic [DW-1:0] rd;
        bit got, seen = 0;
        txn(2, C_WW, CAW'(18), 16'h5A5A, "R2 setup", rd);
        @(negedge clk);
        vid_addr = AW'(9);
        vid_req  = 1;
        drive(1, C_RD, CAW'(6), '0);
        @(negedge clk);
        chk(vid_rvalid && vid_rdata == 16'h5A5A, "R2 video data", 32'(vid_rdata), 32'h5A5A);
        repeat (3) begin
            @(negedge clk);
            if (cpu_ack[1]) seen = 1;
        end
        chk(!seen, "R2 cpu held off", 32'(seen), 0);
        vid_req = 0;
        wait_ack(1, 3, got);
        chk(got && rd_of(1) == 16'hABCD, "R2 cpu after video", 32'(rd_of(1)), 32'hABCD);
        cpu_req[1] = 0;
        @(negedge clk);
    endtask

    task automatic t_blank;
        bit got, seen = 0;
        @(negedge clk);
        blank_n = 1;
        drive(0, C_RD, CAW'(0), '0);
        repeat (5) begin
            @(negedge clk);
            if (cpu_ack[0]) seen = 1;
        end
        chk(!seen, "R3 no grant outside blanking", 32'(seen), 0);
        blank_n = 0;
        wait_ack(0, 3, got);
        chk(got, "R3 grant in blanking", 32'(got), 1);
        cpu_req[0] = 0;
        @(negedge clk);
    endtask

    task automatic t_mutex;
        logic [DW-1:0] rd;
        txn(2, C_TAS, CAW'(2), '0, "R9 tas1", rd);
        chk(rd == 0, "R9 first tas", 32'(rd), 0);
        txn(2, C_TAS, CAW'(2), '0, "R9 tas2", rd);
        chk(rd == 1, "R9 second tas", 32'(rd), 1);
        txn(2, C_MRD, CAW'(2), '0, "R10 rd", rd);
        chk(rd == 1, "R10 read set", 32'(rd), 1);
        txn(2, C_CLR, CAW'(2), '0, "R10 clr", rd);
        chk(rd == 0, "R10 clear result", 32'(rd), 0);
        txn(2, C_MRD, CAW'(2), '0, "R10 rd2", rd);
        chk(rd == 0, "R10 read cleared", 32'(rd), 0);
        txn(2, C_MRD, CAW'(5), '0, "R10 rd5", rd);
        chk(rd == 0, "R10 other mutex", 32'(rd), 0);
    endtask

    task automatic t_race;
        bit got;
        @(negedge clk);
        blank_n = 1;
        drive(0, C_TAS, CAW'(6), '0);
        drive(1, C_TAS, CAW'(6), '0);
        @(negedge clk);
        blank_n = 0;
        wait_ack(0, 3, got);
        chk(got && rd_of(0) == 0, "R11 winner", 32'(rd_of(0)), 0);
        chk(!cpu_ack[1], "R11 loser waits", 32'(cpu_ack[1]), 0);
        cpu_req[0] = 0;
        wait_ack(1, 4, got);
        chk(got && rd_of(1) == 1, "R11 loser sees set", 32'(rd_of(1)), 1);
        cpu_req[1] = 0;
        @(negedge clk);
    endtask

    task automatic t_prio;
        bit got;
        @(negedge clk);
        blank_n = 1;
        drive(0, C_MRD, CAW'(1), '0);
        drive(2, C_RD, CAW'(18), '0);
        @(negedge clk);
        blank_n = 0;
        wait_ack(2, 3, got);
        chk(got && !cpu_ack[0], "R4 memory beats mutex", 32'(cpu_ack), 32'b100);
        chk(rd_of(2) == 16'h5A5A, "R4 memory data", 32'(rd_of(2)), 32'h5A5A);
        cpu_req[2] = 0;
        wait_ack(0, 4, got);
        chk(got, "R4 mutex served next", 32'(got), 1);
        cpu_req[0] = 0;
        @(negedge clk);
    endtask

    task automatic t_order;
        bit got;
        @(negedge clk);
        blank_n = 1;
        drive(2, C_RD, CAW'(0), '0);
        drive(1, C_RD, CAW'(0), '0);
        drive(0, C_RD, CAW'(0), '0);
        @(negedge clk);
        blank_n = 0;
        wait_ack(0, 3, got);
        chk(got && cpu_ack == 3'b001, "R12 cpu0 first", 32'(cpu_ack), 1);
        cpu_req[0] = 0;
        wait_ack(1, 4, got);
        chk(got && cpu_ack == 3'b010, "R12 cpu1 second", 32'(cpu_ack), 2);
        cpu_req[1] = 0;
        wait_ack(2, 4, got);
        chk(got, "R12 cpu2 eventually served", 32'(got), 1);
        cpu_req[2] = 0;
        @(negedge clk);
    endtask

    initial begin
        rst_n = 0; blank_n = 0; vid_req = 0; vid_addr = '0;
        cpu_req = '0; cpu_op = '0; cpu_addr = '0; cpu_wdata = '0;
        #1;
        chk(cpu_ack == 0 && !vid_rvalid, "R1 reset state", 32'(cpu_ack), 0);
        t_wipe;
        t_rw;
        t_video;
        t_blank;
        t_mutex;
        t_race;
        t_prio;
        t_order;
        chk(!multi, "R5 single ack", 32'(multi), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule